// File: doc/BRIEF.md
# Lane-wise floating-point minimum/maximum selector

This block takes two packed vectors of single-precision values and returns, lane by lane, either the smaller or the larger value of each pair. A four-bit type field picks how the choice is made when NaNs or two zeros meet. The five policies are: the IEEE minNum/maxNum rule, a Java-like rule, a rule matching the C ternary macro, a rule matching the C++ standard library template, and a Fortran-like rule. The top bit of the same field switches to magnitude comparison. A single-element mode computes lane 0 only.

Results are registered. The block drives one packed result vector and one invalid-operation flag one clock after the inputs are presented. The flag is the OR of the invalid conditions from every lane that is active. Trapping and any other precision are the caller's concern.

Top module: `fmm_minmax`

## Requirements
- R1: While reset is asserted, and until the internal reset release has passed, `res_o` and `invalid_o` are all zero.
- R2: Inputs sampled at a rising clock edge appear on `res_o` and `invalid_o` just after that edge, a latency of one cycle. The outputs hold until the next edge.
- R3: Lane k occupies bits [32k+31:32k], with sign at bit 31, exponent at bits 30..23 and fraction at bits 22..0. For types 1 to 4 with no NaN and not two zeros, the lane returns the smaller (`max_sel_i`=0) or the larger (`max_sel_i`=1) operand by numeric order. When the operands are equal it returns operand b.
- R4: Type code 0 (IEEE) handles NaNs as follows. If exactly one operand is a quiet NaN and neither operand is signaling, the result is the other operand. If both operands are NaN, or either is signaling, the result is a quietened a when a is a NaN, else a quietened b. A signaling NaN raises invalid. Among numeric operands -0 orders below +0.
- R5: Type code 1 (Java-like) handles NaNs as follows. A signaling a gives a quietened, which means fraction bit 22 is set. Otherwise a signaling b gives b quietened. Otherwise the result is a if a is a NaN, else b.
- R6: Type code 4 (Fortran-like): when either operand is a NaN, the result is a if b is a NaN, else b.
- R7: Type code 2 (C-macro) returns b and type code 3 (C++) returns a whenever either operand is a NaN. Both raise invalid, even for quiet NaNs.
- R8: Two zero operands resolve by type. Type 2 returns b and type 3 returns a. For minimum, types 1 and 4 return a if a is negative, else b. For maximum, types 1 and 4 return b if a is negative, else a.
- R9: In types 1 to 4, any signaling NaN operand in an active lane raises `invalid_o`. A NaN is an all-ones exponent with a nonzero fraction; it is signaling when fraction bit 22 is clear.
- R10: A type field of 8 or more selects magnitude mode, with type equal to the field minus 8. For types 1 to 4 both sign bits are cleared before selection. For type 0 the magnitudes are compared, ties fall back to R4 ordering, and the chosen operand is returned with its original sign.
- R11: Type codes 5, 6 and 7 (fields 5 to 7 and 13 to 15) behave as type 0.
- R12: With `single_i`=1 only lane 0 is computed. Lanes 1 and up read as zero, and their operands do not affect `invalid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a_i | input | 128 | Operand a, four packed lanes |
| op_b_i | input | 128 | Operand b, four packed lanes |
| max_sel_i | input | 1 | 1 = maximum, 0 = minimum |
| kind_fld_i | input | 4 | Type code in bits 2..0, magnitude mode in bit 3 |
| single_i | input | 1 | Compute lane 0 only |
| res_o | output | 128 | Registered result vector |
| invalid_o | output | 1 | Registered invalid-operation flag |

## Verification
The hardest cases to reach are the ones where rules overlap. Examples are a quiet NaN in a alongside a signaling NaN in b, or two zeros of opposite sign under magnitude mode, where the sign clearing must happen before the zero test. The stimulus sweeps every ordered pair from a fourteen-value set of signed zeros, ones, infinities, denormal, quiet and signaling NaNs of both signs. It crosses that sweep with all sixteen type-field codes and both selections. Each lane receives a differently rotated b operand, so all four lanes see distinct pairs in every vector. In single-element mode the upper lanes carry signaling NaNs, which proves they cannot reach the flag.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

  typedef enum logic [2:0] {
    MM_IEEE    = 3'd0,
    MM_JAVA    = 3'd1,
    MM_CMACRO  = 3'd2,
    MM_CPP     = 3'd3,
    MM_FORTRAN = 3'd4
  } mm_kind_e;

  typedef enum logic [2:0] {
    PICK_CMP = 3'd0,
    PICK_A   = 3'd1,
    PICK_B   = 3'd2,
    PICK_QA  = 3'd3,
    PICK_QB  = 3'd4
  } mm_pick_e;

endpackage

// File: rtl/fmm_class.sv
module fmm_class #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] val_i,
  output logic                 nan_o,
  output logic                 snan_o,
  output logic                 zero_o
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic exp_ones;
  logic man_nz;

  always_comb begin
    exp_ones = &val_i[W-2:MAN_W];
    man_nz   = |val_i[MAN_W-1:0];
    nan_o    = exp_ones && man_nz;
    snan_o   = nan_o && !val_i[MAN_W-1];
    zero_o   = (val_i[W-2:0] == '0);
  end
endmodule

// File: rtl/fmm_policy.sv
module fmm_policy
  import fmm_pkg::*;
(
  input  mm_kind_e kind_i,
  input  logic     is_max_i,
  input  logic     nan_a_i,
  input  logic     nan_b_i,
  input  logic     snan_a_i,
  input  logic     snan_b_i,
  input  logic     zero_a_i,
  input  logic     zero_b_i,
  input  logic     neg_a_i,
  output mm_pick_e pick_o,
  output logic     inv_o
);
  logic any_nan;
  logic any_snan;
  logic both_zero;
  mm_pick_e zero_pick;

  always_comb begin
    any_nan   = nan_a_i || nan_b_i;
    any_snan  = snan_a_i || snan_b_i;
    both_zero = zero_a_i && zero_b_i;
    // Java and Fortran share the signed-zero rule.
    if (is_max_i) zero_pick = neg_a_i ? PICK_B : PICK_A;
    else          zero_pick = neg_a_i ? PICK_A : PICK_B;

    pick_o = PICK_CMP;
    inv_o  = any_snan;
    unique case (kind_i)
      MM_JAVA: begin
        if (any_nan) begin
          if (snan_a_i)      pick_o = PICK_QA;
          else if (snan_b_i) pick_o = PICK_QB;
          else               pick_o = nan_a_i ? PICK_A : PICK_B;
        end else if (both_zero) begin
          pick_o = zero_pick;
        end
      end
      MM_FORTRAN: begin
        if (any_nan)        pick_o = nan_b_i ? PICK_A : PICK_B;
        else if (both_zero) pick_o = zero_pick;
      end
      MM_CMACRO: begin
        if (any_nan || both_zero) pick_o = PICK_B;
        inv_o = any_nan;
      end
      MM_CPP: begin
        if (any_nan || both_zero) pick_o = PICK_A;
        inv_o = any_nan;
      end
      default: begin
        if (any_snan || (nan_a_i && nan_b_i)) pick_o = nan_a_i ? PICK_QA : PICK_QB;
        else if (nan_a_i)                     pick_o = PICK_B;
        else if (nan_b_i)                     pick_o = PICK_A;
      end
    endcase
  end
endmodule

// File: rtl/fmm_lane.sv
module fmm_lane
  import fmm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a_i,
  input  logic [EXP_W+MAN_W:0] b_i,
  input  logic                 is_max_i,
  input  mm_kind_e             kind_i,
  input  logic                 abs_i,
  output logic [EXP_W+MAN_W:0] res_o,
  output logic                 inv_o
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] QUIET_BIT = W'(1) << (MAN_W - 1);

  function automatic logic ord_lt(input logic [W-1:0] x, input logic [W-1:0] y);
    if (x[W-1] != y[W-1]) return x[W-1];
    else if (!x[W-1])     return x[W-2:0] < y[W-2:0];
    else                  return x[W-2:0] > y[W-2:0];
  endfunction

  logic [W-1:0] wa, wb;
  logic clear_sign, mag_mode;
  logic nan_a, nan_b, snan_a, snan_b, zero_a, zero_b;
  logic a_less, b_less;
  mm_pick_e pick;

  always_comb begin
    clear_sign = abs_i && (kind_i != MM_IEEE);
    mag_mode   = abs_i && (kind_i == MM_IEEE);
    wa = clear_sign ? {1'b0, a_i[W-2:0]} : a_i;
    wb = clear_sign ? {1'b0, b_i[W-2:0]} : b_i;
  end

  fmm_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
    .val_i(wa), .nan_o(nan_a), .snan_o(snan_a), .zero_o(zero_a));
  fmm_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
    .val_i(wb), .nan_o(nan_b), .snan_o(snan_b), .zero_o(zero_b));

  fmm_policy u_pol (
    .kind_i(kind_i), .is_max_i(is_max_i),
    .nan_a_i(nan_a), .nan_b_i(nan_b), .snan_a_i(snan_a), .snan_b_i(snan_b),
    .zero_a_i(zero_a), .zero_b_i(zero_b), .neg_a_i(wa[W-1]),
    .pick_o(pick), .inv_o(inv_o));

  always_comb begin
    if (mag_mode && (wa[W-2:0] != wb[W-2:0])) begin
      a_less = wa[W-2:0] < wb[W-2:0];
      b_less = wb[W-2:0] < wa[W-2:0];
    end else begin
      a_less = ord_lt(wa, wb);
      b_less = ord_lt(wb, wa);
    end
    unique case (pick)
      PICK_A:  res_o = wa;
      PICK_B:  res_o = wb;
      PICK_QA: res_o = wa | QUIET_BIT;
      PICK_QB: res_o = wb | QUIET_BIT;
      default: begin
        if (is_max_i) res_o = b_less ? wa : wb;
        else          res_o = a_less ? wa : wb;
      end
    endcase
  end
endmodule

// File: rtl/fmm_minmax.sv
module fmm_minmax
  import fmm_pkg::*;
#(
  parameter int LANES = 4,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [LANES*(1+EXP_W+MAN_W)-1:0] op_a_i,
  input  logic [LANES*(1+EXP_W+MAN_W)-1:0] op_b_i,
  input  logic                             max_sel_i,
  input  logic [3:0]                       kind_fld_i,
  input  logic                             single_i,
  output logic [LANES*(1+EXP_W+MAN_W)-1:0] res_o,
  output logic                             invalid_o
);
  localparam int W  = 1 + EXP_W + MAN_W;
  localparam int VW = LANES * W;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta, rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  mm_kind_e kind;
  logic     abs_mode;
  always_comb begin
    abs_mode = kind_fld_i[3];
    unique case (kind_fld_i[2:0])
      3'd1:    kind = MM_JAVA;
      3'd2:    kind = MM_CMACRO;
      3'd3:    kind = MM_CPP;
      3'd4:    kind = MM_FORTRAN;
      default: kind = MM_IEEE;
    endcase
  end

  logic [VW-1:0]    lane_res;
  logic [LANES-1:0] lane_inv;
  logic [LANES-1:0] lane_keep;
  logic [VW-1:0]    res_d, res_q;
  logic             inv_d, inv_q;
  logic             upd_en;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    fmm_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_lane (
      .a_i(op_a_i[k*W +: W]), .b_i(op_b_i[k*W +: W]),
      .is_max_i(max_sel_i), .kind_i(kind), .abs_i(abs_mode),
      .res_o(lane_res[k*W +: W]), .inv_o(lane_inv[k]));
    if (k == 0) begin : g_first
      assign lane_keep[k] = 1'b1;
    end else begin : g_rest
      assign lane_keep[k] = !single_i;
    end
    assign res_d[k*W +: W] = lane_keep[k] ? lane_res[k*W +: W] : '0;
  end

  always_comb begin
    inv_d  = |(lane_inv & lane_keep);
    upd_en = rst_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      inv_q <= 1'b0;
    end else if (!rst_ok) begin
      res_q <= '0;
      inv_q <= 1'b0;
    end else if (upd_en) begin
      res_q <= res_d;
      inv_q <= inv_d;
    end
  end

  assign res_o     = res_q;
  assign invalid_o = inv_q;

  // Lane-0 operand classes, for the checks below.
  logic a0_nan, b0_nan, a0_snan, kind_1to4;
  always_comb begin
    a0_nan    = (&op_a_i[W-2:MAN_W]) && (|op_a_i[MAN_W-1:0]);
    b0_nan    = (&op_b_i[W-2:MAN_W]) && (|op_b_i[MAN_W-1:0]);
    a0_snan   = a0_nan && !op_a_i[MAN_W-1];
    kind_1to4 = (kind_fld_i[2:0] >= 3'd1) && (kind_fld_i[2:0] <= 3'd4);
  end

  p_single_upper_zero_r12: assert property (@(posedge clk) disable iff (!rst_ok)
    single_i |=> (res_o[VW-1:W] == '0));

  p_snan_invalid_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (a0_snan && kind_1to4) |=> invalid_o);

  p_fortran_nan_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (kind_fld_i == 4'd4 && a0_nan && !b0_nan) |=> (res_o[W-1:0] == $past(op_b_i[W-1:0])));

  p_cmacro_nan_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (kind_fld_i == 4'd2 && (a0_nan || b0_nan)) |=>
      (invalid_o && res_o[W-1:0] == $past(op_b_i[W-1:0])));

  p_abs_sign_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    (kind_fld_i[3] && kind_1to4) |=> !res_o[W-1]);
endmodule

// File: tb/fmm_minmax_bench.sv
module fmm_minmax_bench;
  localparam int L = 4;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst_n;
  logic [L*32-1:0] op_a, op_b;
  logic mx;
  logic [3:0] fld;
  logic single;
  logic [L*32-1:0] res;
  logic inv;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fmm_minmax u_fmm_minmax (
    .clk(clk), .rst_n(rst_n), .op_a_i(op_a), .op_b_i(op_b), .max_sel_i(mx),
    .kind_fld_i(fld), .single_i(single), .res_o(res), .invalid_o(inv));

  function automatic logic [31:0] val_of(input int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'h8000_0000;
      2: return 32'h3f80_0000;  3: return 32'hbf80_0000;
      4: return 32'h4000_0000;  5: return 32'hc000_0000;
      6: return 32'h7f80_0000;  7: return 32'hff80_0000;
      8: return 32'h7fc0_0001;  9: return 32'hffc0_0002;
      10: return 32'h7f80_0003; 11: return 32'hff80_0004;
      12: return 32'h0000_0001; default: return 32'hbfc0_0000;
    endcase
  endfunction

  function automatic longint okey(input logic [31:0] x);
    return x[31] ? (-longint'(x[30:0]) - 1) : longint'(x[30:0]);
  endfunction

  // Bench model: bit 32 = invalid, bits 31..0 = lane result.
  function automatic logic [32:0] ref_lane(input logic [31:0] a0, input logic [31:0] b0,
                                           input logic m, input logic [3:0] f);
    int k;
    logic [31:0] a, b, r;
    logic na, nb, sa, sb, za, zb, iv, al, bl;
    k = (f[2:0] > 3'd4) ? 0 : int'(f[2:0]);
    a = (f[3] && k != 0) ? (a0 & 32'h7fff_ffff) : a0;
    b = (f[3] && k != 0) ? (b0 & 32'h7fff_ffff) : b0;
    na = (a[30:23] == 8'hff) && (a[22:0] != 0);
    nb = (b[30:23] == 8'hff) && (b[22:0] != 0);
    sa = na && !a[22];
    sb = nb && !b[22];
    za = (a[30:0] == 0);
    zb = (b[30:0] == 0);
    iv = sa || sb;
    if (f[3] && k == 0 && a[30:0] != b[30:0]) begin
      al = a[30:0] < b[30:0]; bl = b[30:0] < a[30:0];
    end else begin
      al = okey(a) < okey(b); bl = okey(b) < okey(a);
    end
    r = m ? (bl ? a : b) : (al ? a : b);
    if (k == 0) begin
      if (sa || sb || (na && nb)) r = na ? (a | 32'h0040_0000) : (b | 32'h0040_0000);
      else if (na) r = b;
      else if (nb) r = a;
    end else if (na || nb) begin
      case (k)
        1: r = sa ? (a | 32'h0040_0000) : sb ? (b | 32'h0040_0000) : na ? a : b;
        2: begin r = b; iv = 1'b1; end
        3: begin r = a; iv = 1'b1; end
        default: r = nb ? a : b;
      endcase
    end else if (za && zb) begin
      case (k)
        2: r = b;
        3: r = a;
        default: r = m ? (a[31] ? b : a) : (a[31] ? a : b);
      endcase
    end
    return {iv, r};
  endfunction

  function automatic string tag_of(input logic [3:0] f);
    if (f[2:0] > 3'd4) return "R11";
    if (f[3] && f[2:0] != 0) return "R10";
    case (f[2:0])
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2, 3'd3: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [L*32-1:0] er, input logic ei);
    checks++;
    if (res !== er || inv !== ei) begin
      errors++;
      $display("FAIL %s res got %h exp %h invalid got %b exp %b (fld=%0d max=%b single=%b)",
               tag, res, er, inv, ei, fld, mx, single);
    end
  endtask

  task automatic apply(input logic [L*32-1:0] a, input logic [L*32-1:0] b,
                       input logic m, input logic [3:0] f, input logic s, input string tag);
    logic [L*32-1:0] er;
    logic ei;
    logic [32:0] lr;
    @(negedge clk);
    op_a = a; op_b = b; mx = m; fld = f; single = s;
    er = '0; ei = 1'b0;
    for (int k = 0; k < L; k++) begin
      if (k == 0 || !s) begin
        lr = ref_lane(a[k*32 +: 32], b[k*32 +: 32], m, f);
        er[k*32 +: 32] = lr[31:0];
        ei = ei | lr[32];
      end
    end
    @(negedge clk);
    check(tag, er, ei);
  endtask

  task automatic run_all();
    logic [L*32-1:0] a, b;
    // R1: outputs zero in reset, with live inputs present
    op_a = {L{32'h3f80_0000}}; op_b = {L{32'h7f80_0003}};
    mx = 1'b1; fld = 4'd1; single = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", '0, 1'b0);
    repeat (3) @(negedge clk);

    // R3: numeric order, types 1..4
    apply({32'h4000_0000, 32'hbf80_0000, 32'h3f80_0000, 32'hc000_0000},
          {32'h3f80_0000, 32'h3f80_0000, 32'h4000_0000, 32'hbf80_0000}, 1'b0, 4'd3, 1'b0, "R3");
    apply({32'h4000_0000, 32'hbf80_0000, 32'h3f80_0000, 32'hc000_0000},
          {32'h3f80_0000, 32'h3f80_0000, 32'h4000_0000, 32'hbf80_0000}, 1'b1, 4'd4, 1'b0, "R3");
    // R8: signed zeros
    apply({32'h0, 32'h8000_0000, 32'h0, 32'h8000_0000},
          {32'h8000_0000, 32'h0, 32'h0, 32'h8000_0000}, 1'b0, 4'd1, 1'b0, "R8");
    apply({32'h0, 32'h8000_0000, 32'h0, 32'h8000_0000},
          {32'h8000_0000, 32'h0, 32'h0, 32'h8000_0000}, 1'b1, 4'd2, 1'b0, "R8");
    // R9: signaling NaN in lane 2 only
    apply({32'h0, 32'hff80_0004, 32'h0, 32'h0}, {L{32'h3f80_0000}}, 1'b0, 4'd4, 1'b0, "R9");

    // R2: output holds until the edge, then changes
    @(negedge clk);
    op_a = {L{32'h4000_0000}}; op_b = {L{32'hc000_0000}}; mx = 1'b1; fld = 4'd1; single = 1'b0;
    @(negedge clk);
    check("R2", {L{32'h4000_0000}}, 1'b0);
    op_a = {L{32'h3f80_0000}};
    #2;
    check("R2", {L{32'h4000_0000}}, 1'b0);
    @(negedge clk);
    check("R2", {L{32'h3f80_0000}}, 1'b0);

    // Full sweep over value pairs, type fields and selection
    for (int f = 0; f < 16; f++)
      for (int m = 0; m < 2; m++)
        for (int i = 0; i < NV; i++)
          for (int j = 0; j < NV; j++) begin
            for (int k = 0; k < L; k++) begin
              a[k*32 +: 32] = val_of(i);
              b[k*32 +: 32] = val_of((j + 3 * k) % NV);
            end
            apply(a, b, m[0], f[3:0], 1'b0, tag_of(f[3:0]));
          end

    // R12: single-element mode, upper lanes carry signaling NaNs
    for (int f = 0; f < 16; f++)
      for (int m = 0; m < 2; m++)
        for (int i = 0; i < NV; i++)
          for (int j = 0; j < NV; j++) begin
            a = {L{32'h7f80_0003}}; b = {L{32'hff80_0004}};
            a[31:0] = val_of(i); b[31:0] = val_of(j);
            apply(a, b, m[0], f[3:0], 1'b1, "R12");
          end
  endtask

  initial begin
    rst_n = 1'b0;
    op_a = '0; op_b = '0; mx = 1'b0; fld = '0; single = 1'b0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R2 run did not finish: got timeout exp completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule